// File: doc/BRIEF.md
# Burst Read Port Pipeline for a Quad-Data-Rate SRAM Model

This block models the read side of a synchronous SRAM with separate data-in and data-out buses, together with the minimal write path the read side needs to stay coherent. It runs on one clock at twice the rate of the external K clock. An input phase flag, `k_rise`, marks the clock edges that stand for K rising edges. All other edges stand for K# rising edges. The flag must alternate on every edge. Read and write requests share one address bus and are only taken on K-rising edges. Each request moves a burst of four consecutive words, with one word on every edge.

A granted read drives four words from the array onto `rdata`. The first word leaves a fixed number of edges after the request: 2.5 K cycles in the normal mode, or one K cycle in the short legacy mode. A granted write takes its four words from `wdata` on the four edges after the request. A read always returns the most current data. This includes a word that is committed on the same edge it is read, which is served by forwarding `wdata` past the array.

The read output is a stream with `rvalid` and no ready. There is no back-pressure: the consumer must take every beat on the edge it appears. When no beat is present, `rdata` is all zeros. `lat_mode` is a static strap that may only change while no read is pending.

Top module: `qrd_read_port`

## Requirements
- R1: While `rst_n` is low and after it rises, `rvalid` is 0 and `rdata` is all zeros until a read burst is produced.
- R2: `rd_n` and `wr_n` are sampled only on edges where `k_rise` is 1. A low select on a `k_rise`=0 edge starts nothing.
- R3: With `lat_mode`=1, a read granted at edge E puts word index 4*A+0, +1, +2, +3 (A is the captured `addr`) on `rdata` after edges E+5, E+6, E+7 and E+8.
- R4: With `lat_mode`=0, the same burst appears after edges E+2 through E+5.
- R5: `rvalid` is 1 on exactly the half-cycles that carry a burst word, and `rdata` is zero whenever `rvalid` is 0.
- R6: Reads granted every second K cycle yield bursts with no gap between them. A read request on the K-rising edge right after a granted read is ignored.
- R7: A write granted at edge E stores the `wdata` values present at edges E+1 to E+4 into word indices 4*A+0 to 4*A+3.
- R8: When both selects are low on one K-rising edge and the read is granted, the read wins and the write is ignored.
- R9: A burst word output at edge T reflects every write beat committed at or before T, including a beat committed at T itself.
- R10: After `rd_n` returns high, a burst already granted still completes all four beats. `rvalid` then falls on the following edge.
- R11: A write request on the K-rising edge right after a granted write is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; every rising edge is one half K cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| k_rise | input | 1 | 1 on edges standing for K rising, 0 on K# edges |
| lat_mode | input | 1 | 1 = 2.5-cycle latency, 0 = one-cycle legacy latency |
| rd_n | input | 1 | Active-low read request |
| wr_n | input | 1 | Active-low write request |
| addr | input | AW | Shared burst address |
| wdata | input | DW | Write beat data |
| rdata | output | DW | Read beat data, zero when idle |
| rvalid | output | 1 | Read beat present |

## Verification
The two functions that can fall on the same edge are a write beat committing a word and the read burst emitting that same word. The bench provokes this by granting a read and then, two K cycles later, a write to the same address in normal mode, so that every read beat collides with the write beat of the same index. Random mixed traffic also produces such collisions. The bench model applies each edge's write beat before it forms the expected read word, so the design passes only when it returns the new value. A read and a write request on one K-rising edge is also provoked, and it is judged by a later read of the write's address returning the older contents.

// File: rtl/qrd_pkg.sv
package qrd_pkg;
  localparam int BEATS     = 4;
  localparam int BEAT_W    = 2;
  localparam int LAT_FULL  = 5;  // half-cycles, 2.5 K cycles
  localparam int LAT_SHORT = 2;  // half-cycles, one K cycle

  typedef enum logic {
    MODE_SHORT = 1'b0,
    MODE_FULL  = 1'b1
  } lat_mode_e;
endpackage

// File: rtl/qrd_req_ctl.sv
module qrd_req_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic k_rise,
  input  logic rd_n,
  input  logic wr_n,
  output logic rd_take,
  output logic wr_take
);
  logic rd_recent, wr_recent;

  assign rd_take = rst_n & k_rise & ~rd_n & ~rd_recent;
  assign wr_take = rst_n & k_rise & ~wr_n & ~rd_take & ~wr_recent;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_recent <= 1'b0;
      wr_recent <= 1'b0;
    end else if (k_rise) begin
      rd_recent <= rd_take;
      wr_recent <= wr_take;
    end
  end

  // R6: no read grant on the K edge after a granted read
  a_r6_rd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_take |=> ##1 !rd_take);
  // R11: no write grant on the K edge after a granted write
  a_r11_wr_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |=> ##1 !wr_take);
endmodule

// File: rtl/qrd_lat_pipe.sv
module qrd_lat_pipe #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lat_mode,
  input  logic          req,
  input  logic [AW-1:0] req_addr,
  output logic          launch,
  output logic [AW-1:0] launch_addr
);
  localparam int DEPTH = qrd_pkg::LAT_FULL;

  logic          st_v [DEPTH];
  logic [AW-1:0] st_a [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_v[i] <= 1'b0;
          st_a[i] <= '0;
        end else begin
          st_v[i] <= req;
          st_a[i] <= req_addr;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          st_v[i] <= 1'b0;
          st_a[i] <= '0;
        end else begin
          st_v[i] <= st_v[i-1];
          st_a[i] <= st_a[i-1];
        end
      end
    end
  end

  always_comb begin
    if (lat_mode == qrd_pkg::MODE_FULL) begin
      launch      = st_v[qrd_pkg::LAT_FULL-1];
      launch_addr = st_a[qrd_pkg::LAT_FULL-1];
    end else begin
      launch      = st_v[qrd_pkg::LAT_SHORT-1];
      launch_addr = st_a[qrd_pkg::LAT_SHORT-1];
    end
  end
endmodule

// File: rtl/qrd_store.sv
module qrd_store #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_take,
  input  logic [AW-1:0]                addr,
  input  logic [DW-1:0]                wdata,
  input  logic [AW+qrd_pkg::BEAT_W-1:0] rd_idx,
  output logic [DW-1:0]                rd_word
);
  localparam int NWORDS = qrd_pkg::BEATS << AW;

  logic [DW-1:0]               mem [NWORDS];
  logic                        wact;
  logic [AW-1:0]               wbase;
  logic [qrd_pkg::BEAT_W-1:0]  wbeat;
  logic [AW+qrd_pkg::BEAT_W-1:0] widx;

  assign widx = {wbase, wbeat};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wact  <= 1'b0;
      wbase <= '0;
      wbeat <= '0;
    end else begin
      if (wact) begin
        wbeat <= wbeat + 1'b1;
        if (wbeat == qrd_pkg::BEAT_W'(qrd_pkg::BEATS-1)) wact <= 1'b0;
      end
      if (wr_take) begin
        wact  <= 1'b1;
        wbase <= addr;
        wbeat <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wact) mem[widx] <= wdata;
  end

  // forward the beat landing on this edge so reads see the newest word
  assign rd_word = (wact && widx == rd_idx) ? wdata : mem[rd_idx];
endmodule

// File: rtl/qrd_burst_out.sv
module qrd_burst_out #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          launch,
  input  logic [AW-1:0]                 launch_addr,
  input  logic [DW-1:0]                 rd_word,
  output logic [AW+qrd_pkg::BEAT_W-1:0] rd_idx,
  output logic [DW-1:0]                 rdata,
  output logic                          rvalid
);
  logic                       ract;
  logic [AW-1:0]              rbase;
  logic [qrd_pkg::BEAT_W-1:0] rbeat;

  assign rd_idx = launch ? {launch_addr, qrd_pkg::BEAT_W'(0)} : {rbase, rbeat};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ract   <= 1'b0;
      rbase  <= '0;
      rbeat  <= '0;
      rdata  <= '0;
      rvalid <= 1'b0;
    end else if (launch) begin
      ract   <= 1'b1;
      rbase  <= launch_addr;
      rbeat  <= qrd_pkg::BEAT_W'(1);
      rdata  <= rd_word;
      rvalid <= 1'b1;
    end else if (ract) begin
      rbeat  <= rbeat + 1'b1;
      if (rbeat == qrd_pkg::BEAT_W'(qrd_pkg::BEATS-1)) ract <= 1'b0;
      rdata  <= rd_word;
      rvalid <= 1'b1;
    end else begin
      rdata  <= '0;
      rvalid <= 1'b0;
    end
  end

  // R5: idle bus carries zeros
  a_r5_zero_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !rvalid |-> rdata == '0);
endmodule

// File: rtl/qrd_read_port.sv
module qrd_read_port #(
  parameter int AW = 8,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          k_rise,
  input  logic          lat_mode,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  localparam int IW = AW + qrd_pkg::BEAT_W;

  logic          rd_take, wr_take, launch;
  logic [AW-1:0] launch_addr;
  logic [IW-1:0] rd_idx;
  logic [DW-1:0] rd_word;

  qrd_req_ctl u_ctl (
    .clk(clk), .rst_n(rst_n), .k_rise(k_rise), .rd_n(rd_n), .wr_n(wr_n),
    .rd_take(rd_take), .wr_take(wr_take)
  );

  qrd_lat_pipe #(.AW(AW)) u_pipe (
    .clk(clk), .rst_n(rst_n), .lat_mode(lat_mode), .req(rd_take),
    .req_addr(addr), .launch(launch), .launch_addr(launch_addr)
  );

  qrd_store #(.AW(AW), .DW(DW)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_take(wr_take), .addr(addr),
    .wdata(wdata), .rd_idx(rd_idx), .rd_word(rd_word)
  );

  qrd_burst_out #(.AW(AW), .DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .launch(launch), .launch_addr(launch_addr),
    .rd_word(rd_word), .rd_idx(rd_idx), .rdata(rdata), .rvalid(rvalid)
  );

  // R3: full latency, first beat follows the fifth edge after the grant
  a_r3_full_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_mode && $past(lat_mode, 5) && $past(rd_take, 5)) |=> rvalid);
  // R4: legacy latency, first beat follows the second edge after the grant
  a_r4_short_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (!lat_mode && !$past(lat_mode, 2) && $past(rd_take, 2)) |=> rvalid);
endmodule

// File: tb/sim_qrd_read_port.sv
module sim_qrd_read_port;
  localparam int AW = 4;
  localparam int DW = 36;
  localparam int NW = 4 << AW;

  logic          clk = 1'b0;
  logic          rst_n, kr, lat, rd_n, wr_n;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata, rdata;
  logic          rvalid;

  int checks = 0, fails = 0, t = 0;
  bit done = 0;
  string tag = "R1";

  logic [DW-1:0] mem_m [NW];
  bit            sv [64];
  int            sw [64];
  bit            rd_prev_m, wr_prev_m;
  int            wcnt_m, wbase_m;
  bit            exp_v;
  logic [DW-1:0] exp_d;

  qrd_read_port #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .k_rise(kr), .lat_mode(lat), .rd_n(rd_n),
    .wr_n(wr_n), .addr(addr), .wdata(wdata), .rdata(rdata), .rvalid(rvalid)
  );

  always #5 clk = ~clk;

  function automatic logic [DW-1:0] rnd36();
    return {$urandom(), $urandom()} & {DW{1'b1}};
  endfunction

  task automatic check(input bit v, input logic [DW-1:0] d);
    checks++;
    if (rvalid !== v || rdata !== d) begin
      fails++;
      $display("FAIL %s edge=%0d rvalid=%b rdata=%h expected rvalid=%b rdata=%h",
               tag, t, rvalid, rdata, v, d);
    end
  endtask

  // model of one edge, from the requirements
  task automatic model_edge();
    bit ra, wa;
    int lt;
    ra = kr && !rd_n && !rd_prev_m;
    wa = kr && !wr_n && !ra && !wr_prev_m;
    if (kr) begin rd_prev_m = ra; wr_prev_m = wa; end
    if (wcnt_m > 0) begin                       // R7 beats, before read (R9)
      mem_m[wbase_m*4 + (4 - wcnt_m)] = wdata;
      wcnt_m--;
    end
    if (wa) begin wbase_m = int'(addr); wcnt_m = 4; end
    lt = lat ? 5 : 2;
    if (ra)
      for (int b = 0; b < 4; b++) begin
        sv[(t + lt + b) % 64] = 1;
        sw[(t + lt + b) % 64] = int'(addr) * 4 + b;
      end
    exp_v = sv[t % 64];
    exp_d = exp_v ? mem_m[sw[t % 64]] : '0;
    sv[t % 64] = 0;
  endtask

  task automatic step(input bit rn, input bit wn, input logic [AW-1:0] a);
    rd_n = rn; wr_n = wn; addr = a; wdata = rnd36();
    @(posedge clk);
    t++;
    model_edge();
    @(negedge clk);
    check(exp_v, exp_d);
    kr = ~kr;
  endtask

  task automatic kcyc(input bit rn, input bit wn, input logic [AW-1:0] a,
                      input bit rn_half);
    step(rn, wn, a);
    step(rn_half, 1'b1, AW'($urandom()));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) kcyc(1'b1, 1'b1, '0, 1'b1);
  endtask

  initial begin
    void'($urandom(32'h51AB));
    for (int i = 0; i < 64; i++) begin sv[i] = 0; sw[i] = 0; end
    rd_prev_m = 0; wr_prev_m = 0; wcnt_m = 0; wbase_m = 0;
    rst_n = 0; kr = 0; lat = 1; rd_n = 0; wr_n = 0; addr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    tag = "R1";
    checks++;
    if (rvalid !== 1'b0 || rdata !== '0) begin
      fails++;
      $display("FAIL R1 in reset rvalid=%b rdata=%h expected 0 0", rvalid, rdata);
    end
    rst_n = 1; kr = 1; rd_n = 1; wr_n = 1;
    check(1'b0, '0);

    // fill every word (R7)
    tag = "R7";
    for (int i = 0; i < NW / 4; i++) begin
      kcyc(1'b1, 1'b0, AW'(i), 1'b1);
      kcyc(1'b1, 1'b1, '0, 1'b1);
    end
    idle(3);

    // R3 and R6: gapless reads every second K cycle, full latency
    tag = "R3 R6";
    for (int i = 0; i < 4; i++) begin
      kcyc(1'b0, 1'b1, AW'(i * 3 + 1), 1'b1);
      kcyc(1'b1, 1'b1, '0, 1'b1);
    end
    idle(5);
    // R6: read on the very next K edge is ignored
    tag = "R6";
    kcyc(1'b0, 1'b1, AW'(5), 1'b1);
    kcyc(1'b0, 1'b1, AW'(9), 1'b1);
    idle(5);

    // R2: select low only on K# edges
    tag = "R2";
    for (int i = 0; i < 4; i++) kcyc(1'b1, 1'b1, AW'(7), 1'b0);
    idle(4);

    // R10 and R5: deselect right after the grant, burst still completes
    tag = "R10 R5";
    kcyc(1'b0, 1'b1, AW'(11), 1'b1);
    idle(6);

    // R8: both selects on one K edge, read wins; later read shows old data
    tag = "R8";
    kcyc(1'b0, 1'b0, AW'(2), 1'b1);
    idle(4);
    kcyc(1'b0, 1'b1, AW'(2), 1'b1);
    idle(5);

    // R9: write lands on each word the same edge it is read
    tag = "R9";
    kcyc(1'b0, 1'b1, AW'(6), 1'b1);
    kcyc(1'b1, 1'b1, '0, 1'b1);
    kcyc(1'b1, 1'b0, AW'(6), 1'b1);
    idle(5);
    kcyc(1'b0, 1'b1, AW'(6), 1'b1);
    idle(5);

    // R11: write on the next K edge after a write is ignored
    tag = "R11";
    kcyc(1'b1, 1'b0, AW'(3), 1'b1);
    kcyc(1'b1, 1'b0, AW'(4), 1'b1);
    idle(3);
    kcyc(1'b0, 1'b1, AW'(4), 1'b1);
    idle(5);

    // R4: legacy latency
    lat = 0;
    tag = "R4";
    for (int i = 0; i < 3; i++) begin
      kcyc(1'b0, 1'b1, AW'(i + 8), 1'b1);
      kcyc(1'b1, 1'b1, '0, 1'b1);
    end
    kcyc(1'b1, 1'b0, AW'(8), 1'b1);
    kcyc(1'b0, 1'b1, AW'(8), 1'b1);
    idle(5);

    // random traffic in both modes
    for (int m = 0; m < 2; m++) begin
      lat = (m == 0);
      tag = (m == 0) ? "R9 R3" : "R9 R4";
      for (int i = 0; i < 300; i++)
        kcyc(($urandom() % 3) == 0 ? 1'b1 : 1'b0, $urandom() % 2 == 0 ? 1'b1 : 1'b0,
             AW'($urandom()), $urandom() % 2 == 0 ? 1'b1 : 1'b0);
      idle(6);
    end

    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired at edge %0d", t);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule